// File: doc/BRIEF.md
# Multi-Representation Integer Adder

This block adds two W-bit operands under one of four number interpretations picked per operation by a two-bit mode input: plain unsigned, two's complement, one's complement, or excess-K biased. One full-adder ripple chain forms the raw sum for every mode. One's complement mode sends the carry out of that chain back in through a second incrementing pass. Biased mode takes the constant bias off the raw sum through a third chain one bit wider. Each mode defines its own carry-out and overflow.

In the two complement modes, a subtract input inverts the subtrahend before the add. Two's complement mode also sets the initial carry to one. In unsigned or biased mode a subtract request is refused: the error flag rises and the result and flags read as zero. An output stage chosen by parameter either registers the result with a valid bit or passes it straight through. Multiplication, division, saturation and conversion between representations are not part of the block.

Top module: `mrep_adder`

## Requirements
- R1: Mode encoding is 00 unsigned, 01 two's complement, 10 one's complement and 11 biased. In unsigned add, `sum` is (a+b) mod 2^W, `carry_out` is bit W of a+b, and `overflow` equals `carry_out` (for example 1111+0001 gives 0000 with both flags set).
- R2: In two's complement mode, `sum` is (a+b) mod 2^W, or (a+~b+1) mod 2^W when `sub` is 1. `carry_out` is the raw carry out of the MSB and does not affect `sum`. `overflow` is 1 exactly when the signed result lies outside -2^(W-1) to 2^(W-1)-1.
- R3: In one's complement mode, the first pass adds a to b (or to ~b when `sub` is 1) with a zero carry-in. `sum` is that pass's low W bits plus its carry out, modulo 2^W, and `carry_out` reports the carry of the first pass (for example 1101+1011 gives 1001 with carry 1).
- R4: In one's complement mode, `overflow` is 1 exactly when both effective operands have the same sign bit and `sum` has the other sign bit, which equals the true result lying outside -(2^(W-1)-1) to 2^(W-1)-1.
- R5: In biased add with bias K (parameter BIAS, default 2^(W-1)), `sum` is (a+b-K) mod 2^W. `carry_out` is bit W of a+b. `overflow` is 1 when a+b-K is below 0 or above 2^W-1.
- R6: When `sub` is 1 in unsigned or biased mode, `err` is 1 and `sum`, `carry_out` and `overflow` are all 0.
- R7: `err` is 0 for every add, and for every subtract in the two complement modes.
- R8: With REG_OUT=1, a result whose inputs were presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high. `out_valid` is otherwise low. Reset, which is asynchronous and active low, clears `out_valid`, `sum` and all flags to 0.
- R9: With REG_OUT=1, a clock with `in_valid` low leaves `sum`, `carry_out`, `overflow` and `err` unchanged and drives `out_valid` low.
- R10: With REG_OUT=0, the outputs follow the inputs in the same cycle, and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | Representation select (00 unsigned, 01 two's, 10 one's, 11 biased) |
| sub | input | 1 | Subtract b from a (complement modes only) |
| a | input | W | First operand |
| b | input | W | Second operand / subtrahend |
| out_valid | output | 1 | Result on the outputs is valid |
| sum | output | W | Result in the selected representation |
| carry_out | output | 1 | Carry out of the MSB for the selected mode |
| overflow | output | 1 | Result not representable in the selected mode |
| err | output | 1 | Unsupported subtract requested |

## Verification
The bench builds two copies of the block. The first has W=6, a bias of 20 and a registered output. Its 64x64 operand space is small enough to sweep completely in all four modes, for both add and subtract, against a behavioural model. The non-power-of-two bias brings both biased overflow edges (raw sum below K, and corrected value above 2^W-1) into reach from ordinary operands. The second copy has W=4, the default bias of 8 and a pass-through output. It walks a table of hand-worked 4-bit cases: end-around carry, negative zero, and signed limits. It also shows the same-cycle path of the combinational variant.

// File: rtl/mrep_pkg.sv
package mrep_pkg;

   typedef enum logic [1:0] {
      REP_UNS  = 2'b00,
      REP_TWOS = 2'b01,
      REP_ONES = 2'b10,
      REP_BIAS = 2'b11
   } rep_e;

   typedef struct packed {
      logic carry;
      logic ovf;
      logic err;
   } flag_t;

endpackage

// File: rtl/mrep_fa.sv
module mrep_fa (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   always_comb begin
      s  = x ^ y ^ ci;
      co = (x & y) | (ci & (x ^ y));
   end
endmodule

// File: rtl/mrep_ripple.sv
module mrep_ripple #(
   parameter int N = 8
) (
   input  logic [N-1:0] x,
   input  logic [N-1:0] y,
   input  logic         cin,
   output logic [N-1:0] s,
   output logic         cout
);
   logic [N:0] cy;

   assign cy[0] = cin;

   for (genvar i = 0; i < N; i++) begin : g_bit
      mrep_fa u_fa (
         .x  (x[i]),
         .y  (y[i]),
         .ci (cy[i]),
         .s  (s[i]),
         .co (cy[i+1])
      );
   end

   assign cout = cy[N];
endmodule

// File: rtl/mrep_core.sv
module mrep_core
   import mrep_pkg::*;
#(
   parameter int W    = 8,
   parameter int BIAS = 2 ** (W - 1)
) (
   input  rep_e         md,
   input  logic         sub,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res,
   output flag_t        flg
);
   localparam int       MSB   = W - 1;
   localparam logic [W:0] NEG_K = ~((W + 1)'(BIAS));

   logic         is_cmp;
   logic         unsup;
   logic [W-1:0] b_eff;
   logic         cin0;

   // first pass: shared by every mode
   logic [W-1:0] s1;
   logic         c1;
   // second pass: end-around carry for one's complement
   logic [W-1:0] s2;
   logic         c2;
   // third pass: bias removal, one bit wider
   logic [W:0]   dk;
   logic         nb;

   always_comb begin
      is_cmp = (md == REP_TWOS) || (md == REP_ONES);
      unsup  = sub && !is_cmp;
      b_eff  = (sub && is_cmp) ? ~b : b;
      cin0   = sub && (md == REP_TWOS);
   end

   mrep_ripple #(.N(W)) u_main (
      .x    (a),
      .y    (b_eff),
      .cin  (cin0),
      .s    (s1),
      .cout (c1)
   );

   mrep_ripple #(.N(W)) u_eac (
      .x    (s1),
      .y    ('0),
      .cin  (c1),
      .s    (s2),
      .cout (c2)
   );

   mrep_ripple #(.N(W + 1)) u_bias (
      .x    ({c1, s1}),
      .y    (NEG_K),
      .cin  (1'b1),
      .s    (dk),
      .cout (nb)
   );

   always_comb begin
      res = '0;
      flg = '0;
      if (unsup) begin
         flg.err = 1'b1;
      end else begin
         unique case (md)
            REP_UNS: begin
               res       = s1;
               flg.carry = c1;
               flg.ovf   = c1;
            end
            REP_TWOS: begin
               res       = s1;
               flg.carry = c1;
               flg.ovf   = (a[MSB] == b_eff[MSB]) && (s1[MSB] != a[MSB]);
            end
            REP_ONES: begin
               res       = s2;
               flg.carry = c1 | c2;
               flg.ovf   = (a[MSB] == b_eff[MSB]) && (s2[MSB] != a[MSB]);
            end
            default: begin
               res       = dk[W-1:0];
               flg.carry = c1;
               flg.ovf   = !nb || dk[W];
            end
         endcase
      end
   end
endmodule

// File: rtl/mrep_out_stage.sv
module mrep_out_stage
   import mrep_pkg::*;
#(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] res_i,
   input  flag_t        flg_i,
   output logic         out_valid,
   output logic [W-1:0] res_o,
   output flag_t        flg_o
);
   if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] res_q;
      flag_t        flg_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
            flg_q <= '0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) begin
               res_q <= res_i;
               flg_q <= flg_i;
            end
         end
      end

      assign out_valid = vld_q;
      assign res_o     = res_q;
      assign flg_o     = flg_q;

      // R8
      capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (out_valid && res_o == $past(res_i) && flg_o == $past(flg_i)));

      // R8
      idle_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);

      // R9
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(res_o) && $stable(flg_o)));
   end else begin : g_pass
      assign out_valid = in_valid;
      assign res_o     = res_i;
      assign flg_o     = flg_i;
   end
endmodule

// File: rtl/mrep_adder.sv
module mrep_adder
   import mrep_pkg::*;
#(
   parameter int W       = 8,
   parameter int BIAS    = 2 ** (W - 1),
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [1:0]   mode,
   input  logic         sub,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         out_valid,
   output logic [W-1:0] sum,
   output logic         carry_out,
   output logic         overflow,
   output logic         err
);
   localparam int MSB = W - 1;

   if (W < 2 || W > 30) begin : g_bad_width
      $error("mrep_adder: W must lie in 2..30");
   end
   if (BIAS < 0 || BIAS > (2 ** W) - 1) begin : g_bad_bias
      $error("mrep_adder: BIAS must lie in 0..2^W-1");
   end

   rep_e         md;
   logic [W-1:0] c_res;
   flag_t        c_flg;
   flag_t        o_flg;

   assign md = rep_e'(mode);

   mrep_core #(.W(W), .BIAS(BIAS)) u_core (
      .md  (md),
      .sub (sub),
      .a   (a),
      .b   (b),
      .res (c_res),
      .flg (c_flg)
   );

   // R2: sign rule must agree with carry-in vs carry-out of the MSB
   // R2
   twos_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (md == REP_TWOS) |->
         (c_flg.ovf == (a[MSB] ^ b[MSB] ^ sub ^ c_res[MSB] ^ c_flg.carry)));

   // R4
   ones_ovf_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (md == REP_ONES && c_flg.ovf) |-> (c_res[MSB] != a[MSB]));

   // R6
   unsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub && (md == REP_UNS || md == REP_BIAS)) |->
         (c_flg.err && c_res == '0 && !c_flg.carry && !c_flg.ovf));

   // R7
   no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub || md == REP_TWOS || md == REP_ONES) |-> !c_flg.err);

   // R1
   uns_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (md == REP_UNS && !sub) |->
         ({c_flg.carry, c_res} == ({1'b0, a} + {1'b0, b})));

   mrep_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .res_i     (c_res),
      .flg_i     (c_flg),
      .out_valid (out_valid),
      .res_o     (sum),
      .flg_o     (o_flg)
   );

   assign carry_out = o_flg.carry;
   assign overflow  = o_flg.ovf;
   assign err       = o_flg.err;
endmodule

// File: tb/sim_mrep_adder.sv
module sim_mrep_adder;

   localparam int W0 = 6;
   localparam int B0 = 20;
   localparam int M0 = 64;
   localparam int H0 = 32;
   localparam int W1 = 4;

   // {mode, sub, a, b, sum, carry, ovf, err} for the 4-bit copy, bias 8
   localparam logic [17:0] VEC [20] = '{
      {2'd0, 1'b0, 4'hF, 4'h1, 4'h0, 1'b1, 1'b1, 1'b0},
      {2'd0, 1'b0, 4'h3, 4'h1, 4'h4, 1'b0, 1'b0, 1'b0},
      {2'd1, 1'b0, 4'h5, 4'hD, 4'h2, 1'b1, 1'b0, 1'b0},
      {2'd1, 1'b0, 4'h5, 4'h2, 4'h7, 1'b0, 1'b0, 1'b0},
      {2'd1, 1'b0, 4'h9, 4'h7, 4'h0, 1'b1, 1'b0, 1'b0},
      {2'd1, 1'b0, 4'h7, 4'h7, 4'hE, 1'b0, 1'b1, 1'b0},
      {2'd1, 1'b1, 4'h3, 4'h5, 4'hE, 1'b0, 1'b0, 1'b0},
      {2'd1, 1'b1, 4'h8, 4'h1, 4'h7, 1'b1, 1'b1, 1'b0},
      {2'd2, 1'b0, 4'hD, 4'hB, 4'h9, 1'b1, 1'b0, 1'b0},
      {2'd2, 1'b0, 4'h3, 4'hC, 4'hF, 1'b0, 1'b0, 1'b0},
      {2'd2, 1'b0, 4'h7, 4'hC, 4'h4, 1'b1, 1'b0, 1'b0},
      {2'd2, 1'b0, 4'h6, 4'h3, 4'h9, 1'b0, 1'b1, 1'b0},
      {2'd2, 1'b1, 4'h2, 4'h5, 4'hC, 1'b0, 1'b0, 1'b0},
      {2'd2, 1'b1, 4'h5, 4'h2, 4'h3, 1'b1, 1'b0, 1'b0},
      {2'd3, 1'b0, 4'hA, 4'h9, 4'hB, 1'b1, 1'b0, 1'b0},
      {2'd3, 1'b0, 4'h3, 4'h4, 4'hF, 1'b0, 1'b1, 1'b0},
      {2'd3, 1'b0, 4'hF, 4'h9, 4'h0, 1'b1, 1'b1, 1'b0},
      {2'd3, 1'b0, 4'h8, 4'h8, 4'h8, 1'b1, 1'b0, 1'b0},
      {2'd0, 1'b1, 4'h5, 4'h1, 4'h0, 1'b0, 1'b0, 1'b1},
      {2'd3, 1'b1, 4'h8, 4'h8, 4'h0, 1'b0, 1'b0, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic          v0_in = 1'b0;
   logic [1:0]    m0 = 2'd0;
   logic          s0 = 1'b0;
   logic [W0-1:0] a0 = '0;
   logic [W0-1:0] b0 = '0;
   logic          v0_out;
   logic [W0-1:0] q0;
   logic          c0, o0, e0;

   logic          v1_in = 1'b0;
   logic [1:0]    m1 = 2'd0;
   logic          s1 = 1'b0;
   logic [W1-1:0] a1 = '0;
   logic [W1-1:0] b1 = '0;
   logic          v1_out;
   logic [W1-1:0] q1;
   logic          c1, o1, e1;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   mrep_adder #(.W(W0), .BIAS(B0), .REG_OUT(1'b1)) u0 (
      .clk (clk), .rst_n (rst_n), .in_valid (v0_in), .mode (m0), .sub (s0),
      .a (a0), .b (b0), .out_valid (v0_out), .sum (q0),
      .carry_out (c0), .overflow (o0), .err (e0)
   );

   mrep_adder #(.W(W1), .REG_OUT(1'b0)) u1 (
      .clk (clk), .rst_n (rst_n), .in_valid (v1_in), .mode (m1), .sub (s1),
      .a (a1), .b (b1), .out_valid (v1_out), .sum (q1),
      .carry_out (c1), .overflow (o1), .err (e1)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   function automatic string tag(input int md, input int sb);
      if (sb != 0 && (md == 0 || md == 3)) return "R6";
      case (md)
         0:       return "R1 R7";
         1:       return "R2 R7";
         2:       return "R3 R4 R7";
         default: return "R5 R7";
      endcase
   endfunction

   // behavioural model of the 6-bit copy: {sum, carry, ovf, err}
   function automatic logic [8:0] model0(input int md, input int sb,
                                         input int a, input int b);
      int s, bb, rs, c, o, e, va, vb, t;
      rs = 0; c = 0; o = 0; e = 0;
      case (md)
         0: begin
            if (sb != 0) e = 1;
            else begin s = a + b; rs = s % M0; c = s / M0; o = c; end
         end
         1: begin
            bb = (sb != 0) ? (M0 - 1 - b) : b;
            s  = a + bb + sb;
            rs = s % M0; c = s / M0;
            va = (a >= H0) ? a - M0 : a;
            vb = (b >= H0) ? b - M0 : b;
            t  = (sb != 0) ? va - vb : va + vb;
            o  = (t > H0 - 1 || t < -H0) ? 1 : 0;
         end
         2: begin
            bb = (sb != 0) ? (M0 - 1 - b) : b;
            s  = a + bb;
            c  = s / M0;
            rs = ((s % M0) + c) % M0;
            va = (a >= H0) ? a - (M0 - 1) : a;
            vb = (b >= H0) ? b - (M0 - 1) : b;
            t  = (sb != 0) ? va - vb : va + vb;
            o  = (t > H0 - 1 || t < -(H0 - 1)) ? 1 : 0;
         end
         default: begin
            if (sb != 0) e = 1;
            else begin
               s  = a + b; c = s / M0;
               t  = s - B0;
               o  = (t < 0 || t > M0 - 1) ? 1 : 0;
               rs = ((t % M0) + M0) % M0;
            end
         end
      endcase
      return {rs[5:0], c[0], o[0], e[0]};
   endfunction

   initial begin
      #1_000_000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [8:0] exp0;
      logic [8:0] held;
      // reset state, R8
      repeat (2) @(posedge clk);
      #1;
      chk(v0_out == 1'b0, "R8", "reset out_valid", int'(v0_out), 0);
      chk({q0, c0, o0, e0} == '0, "R8", "reset outputs", int'({q0, c0, o0, e0}), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk on the 4-bit pass-through copy
      v1_in = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         {m1, s1, a1, b1} = VEC[i][17:7];
         #2;
         chk({q1, c1, o1, e1} == VEC[i][6:0], tag(int'(VEC[i][17:16]), int'(VEC[i][15])),
             $sformatf("vec %0d", i), int'({q1, c1, o1, e1}), int'(VEC[i][6:0]));
         // R10
         chk(v1_out == 1'b1, "R10", "pass valid", int'(v1_out), 1);
      end
      @(negedge clk);
      v1_in = 1'b0;
      #1;
      chk(v1_out == 1'b0, "R10", "pass valid low", int'(v1_out), 0);

      // exhaustive sweep of the registered 6-bit copy
      for (int md = 0; md < 4; md++) begin
         for (int sb = 0; sb < 2; sb++) begin
            for (int x = 0; x < M0; x++) begin
               for (int y = 0; y < M0; y++) begin
                  @(negedge clk);
                  v0_in = 1'b1; m0 = md[1:0]; s0 = sb[0];
                  a0 = x[5:0]; b0 = y[5:0];
                  exp0 = model0(md, sb, x, y);
                  @(posedge clk);
                  #1;
                  if ({q0, c0, o0, e0} != exp0 || !v0_out)
                     chk(1'b0, tag(md, sb),
                         $sformatf("m=%0d s=%0d a=%0d b=%0d", md, sb, x, y),
                         int'({v0_out, q0, c0, o0, e0}), int'({1'b1, exp0}));
                  else
                     n_chk++;
               end
            end
         end
      end

      // hold with in_valid low, R9
      held = {q0, c0, o0, e0};
      @(negedge clk);
      v0_in = 1'b0; m0 = 2'd1; s0 = 1'b0; a0 = 6'd31; b0 = 6'd1;
      @(posedge clk);
      #1;
      chk(v0_out == 1'b0, "R9", "idle out_valid", int'(v0_out), 0);
      chk({q0, c0, o0, e0} == held, "R9", "hold outputs",
          int'({q0, c0, o0, e0}), int'(held));
      // one-cycle latency after re-enable, R8
      @(negedge clk);
      v0_in = 1'b1;
      #1;
      chk({q0, c0, o0, e0} == held, "R8", "no change before edge",
          int'({q0, c0, o0, e0}), int'(held));
      @(posedge clk);
      #1;
      exp0 = model0(1, 0, 31, 1);
      chk({v0_out, q0, c0, o0, e0} == {1'b1, exp0}, "R8", "captured after edge",
          int'({v0_out, q0, c0, o0, e0}), int'({1'b1, exp0}));

      // asynchronous reset mid-run, R8
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk({v0_out, q0, c0, o0, e0} == '0, "R8", "async clear",
          int'({v0_out, q0, c0, o0, e0}), 0);

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule